// File: doc/BRIEF.md
# Audio Sample DMA Request Arbiter

This block raises DMA request lines for the two sample streams of an audio codec: playback, where the host writes samples into the codec, and capture, where the host reads them out. Each stream has an enable bit and an internal flag. For playback the flag means the codec wants a sample. For capture it means a sample is waiting. When both are set, the stream raises its request. The request stays up while the host moves the sample one byte at a time. A byte is counted on a write strobe (playback) or a read strobe (capture), but only while the matching acknowledge is high. The request drops in the same cycle as the strobe that carries the last byte of the sample.

There are two routing modes. In dual mode each stream has its own request and acknowledge pair. In single-channel mode the capture stream is moved onto the playback pair. Playback has priority in that mode, and the capture pair stays silent. A programmed-I/O input turns off DMA requests entirely, and it also overrides the single-channel setting.

If an enable is cleared while its request is still up, the request is allowed to finish one whole sample before it stops. The sample size is selected per transfer setup as 1, 2 or 4 bytes.

Top module: `dma_req_arbiter`

## Requirements
- R1: While reset is asserted, and after it is released with no stream enabled, both request outputs are low.
- R2: In dual mode, a stream whose enable and its sample-needed (playback) or sample-ready (capture) flag are both high raises its own request output on the next rising clock edge.
- R3: The size code selects the bytes per sample: 0 gives 1 byte, 1 gives 2 bytes, and 2 or 3 give 4 bytes. The request output goes low combinationally during the strobe that completes the last byte. It stays low after that clock edge while the stream's flag is low.
- R4: A byte is counted only when the stream's own direction strobe is high (write for playback, read for capture) and its routed acknowledge is high. Unacknowledged strobes and strobes in the wrong direction do not move the sample toward completion.
- R5: Clearing an enable while its request is up keeps the request up until one more full sample has been transferred. After that, no new request is raised while the enable stays low.
- R6: A stream whose enable is low never raises a request, whatever its flag does.
- R7: In dual mode the two streams are independent: completing a sample on one leaves the other's request unchanged.
- R8: In single-channel mode, a capture request appears on the playback request output and is acknowledged through the playback acknowledge input.
- R9: In single-channel mode the capture request output is held low, and the capture acknowledge input has no effect.
- R10: In single-channel mode with both enables high, capture never raises a request. Capture can raise one once playback is disabled.
- R11: With the programmed-I/O input high, no request is raised in either mode, and the single-channel setting has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| play_en_i | input | 1 | Playback stream enable |
| cap_en_i | input | 1 | Capture stream enable |
| single_chan_i | input | 1 | 1 = both streams share the playback request/acknowledge pair |
| pio_mode_i | input | 1 | 1 = transfers use programmed I/O, DMA requests off |
| sample_size_i | input | 2 | Bytes per sample: 0→1, 1→2, 2/3→4 |
| play_need_i | input | 1 | Codec wants a playback sample |
| cap_ready_i | input | 1 | Codec holds a captured sample |
| play_ack_i | input | 1 | Playback-pair acknowledge |
| cap_ack_i | input | 1 | Capture-pair acknowledge |
| wr_strobe_i | input | 1 | Host write strobe (one playback byte) |
| rd_strobe_i | input | 1 | Host read strobe (one capture byte) |
| play_req_o | output | 1 | Playback-pair DMA request |
| cap_req_o | output | 1 | Capture-pair DMA request |

## Verification
One sample transfer is run for every combination of routing mode, stream and size code. Each run checks which pin carries the request, whether the other pin stays low, and on which acknowledged strobe the request falls. This separates the byte-count decoding and the routing paths. Each run is preceded by unacknowledged strobes, wrong-direction strobes and a stray capture acknowledge. These show that only qualified strobes are counted. Further directed patterns cover the following:
- clearing an enable while a request is pending, and an enable held low, which separate the finish-last-sample rule from plain gating;
- both streams active in dual mode, which checks that they are independent;
- both enabled in single-channel mode, which checks playback priority;
- programmed-I/O mode under both routing settings.

// File: rtl/dmaarb_pkg.sv
`timescale 1ns/1ps
package dmaarb_pkg;

  localparam int STREAM_PLAY = 0;
  localparam int STREAM_CAP  = 1;
  localparam int NUM_STREAMS = 2;

  typedef enum logic [1:0] {
    SZ_ONE      = 2'd0,
    SZ_TWO      = 2'd1,
    SZ_FOUR     = 2'd2,
    SZ_FOUR_ALT = 2'd3
  } samp_size_e;

  // Index of the final byte of a sample for a given size code.
  function automatic int unsigned last_byte_idx(input samp_size_e sz);
    case (sz)
      SZ_ONE:  return 0;
      SZ_TWO:  return 1;
      default: return 3;
    endcase
  endfunction

endpackage

// File: rtl/dmaarb_rst_sync.sv
`timescale 1ns/1ps
module dmaarb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/dmaarb_stream.sv
`timescale 1ns/1ps
module dmaarb_stream #(
  parameter int MAX_BYTES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       avail_i,
  input  logic       ack_i,
  input  logic       strobe_i,
  input  logic [1:0] size_i,
  output logic       req_o
);
  import dmaarb_pkg::*;

  localparam int CNT_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

  logic             req_q, req_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last_idx;
  logic             beat;
  logic             sample_done;
  logic             raise;
  logic             upd_en;

  assign last_idx    = CNT_W'(last_byte_idx(samp_size_e'(size_i)));
  assign beat        = req_q & ack_i & strobe_i;
  assign sample_done = beat & (cnt_q == last_idx);
  assign raise       = ~req_q & en_i & avail_i;
  assign upd_en      = beat | raise;

  always_comb begin
    req_d = req_q;
    cnt_d = cnt_q;
    if (beat) begin
      if (sample_done) begin
        cnt_d = '0;
        req_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (raise) begin
      req_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      cnt_q <= '0;
    end else if (upd_en) begin
      req_q <= req_d;
      cnt_q <= cnt_d;
    end
  end

  assign req_o = req_q & ~sample_done;

  AST_REQ_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !(ack_i && strobe_i)) |=> req_q); // R5

  AST_NO_RAISE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_q && !en_i) |=> !req_q); // R6

  AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !req_q |-> (cnt_q == '0)); // R4

  AST_CNT_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_i && strobe_i) |=> $stable(cnt_q)); // R4

endmodule

// File: rtl/dmaarb_route.sv
`timescale 1ns/1ps
module dmaarb_route (
  input  logic       play_en_i,
  input  logic       cap_en_i,
  input  logic       single_chan_i,
  input  logic       pio_mode_i,
  input  logic       play_ack_i,
  input  logic       cap_ack_i,
  input  logic [1:0] eng_req_i,
  output logic [1:0] eng_en_o,
  output logic [1:0] eng_ack_o,
  output logic       play_req_o,
  output logic       cap_req_o
);
  import dmaarb_pkg::*;

  logic single_eff;
  logic dma_ok;

  always_comb begin
    single_eff = single_chan_i & ~pio_mode_i;
    dma_ok     = ~pio_mode_i;

    eng_en_o[STREAM_PLAY] = play_en_i & dma_ok;
    eng_en_o[STREAM_CAP]  = cap_en_i & dma_ok & ~(single_eff & play_en_i);

    eng_ack_o[STREAM_PLAY] = play_ack_i;
    eng_ack_o[STREAM_CAP]  = single_eff ? play_ack_i : cap_ack_i;

    play_req_o = eng_req_i[STREAM_PLAY] | (single_eff & eng_req_i[STREAM_CAP]);
    cap_req_o  = eng_req_i[STREAM_CAP] & ~single_eff;
  end

endmodule

// File: rtl/dma_req_arbiter.sv
`timescale 1ns/1ps
module dma_req_arbiter #(
  parameter int MAX_BYTES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       play_en_i,
  input  logic       cap_en_i,
  input  logic       single_chan_i,
  input  logic       pio_mode_i,
  input  logic [1:0] sample_size_i,
  input  logic       play_need_i,
  input  logic       cap_ready_i,
  input  logic       play_ack_i,
  input  logic       cap_ack_i,
  input  logic       wr_strobe_i,
  input  logic       rd_strobe_i,
  output logic       play_req_o,
  output logic       cap_req_o
);
  import dmaarb_pkg::*;

  logic                   srst_n;
  logic [NUM_STREAMS-1:0] eng_en;
  logic [NUM_STREAMS-1:0] eng_ack;
  logic [NUM_STREAMS-1:0] eng_req;
  logic [NUM_STREAMS-1:0] eng_avail;
  logic [NUM_STREAMS-1:0] eng_strobe;

  assign eng_avail[STREAM_PLAY]  = play_need_i;
  assign eng_avail[STREAM_CAP]   = cap_ready_i;
  assign eng_strobe[STREAM_PLAY] = wr_strobe_i;
  assign eng_strobe[STREAM_CAP]  = rd_strobe_i;

  dmaarb_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
    dmaarb_stream #(.MAX_BYTES(MAX_BYTES)) u_eng (
      .clk      (clk),
      .rst_n    (srst_n),
      .en_i     (eng_en[s]),
      .avail_i  (eng_avail[s]),
      .ack_i    (eng_ack[s]),
      .strobe_i (eng_strobe[s]),
      .size_i   (sample_size_i),
      .req_o    (eng_req[s])
    );
  end

  dmaarb_route u_route (
    .play_en_i     (play_en_i),
    .cap_en_i      (cap_en_i),
    .single_chan_i (single_chan_i),
    .pio_mode_i    (pio_mode_i),
    .play_ack_i    (play_ack_i),
    .cap_ack_i     (cap_ack_i),
    .eng_req_i     (eng_req),
    .eng_en_o      (eng_en),
    .eng_ack_o     (eng_ack),
    .play_req_o    (play_req_o),
    .cap_req_o     (cap_req_o)
  );

  AST_SINGLE_CAP_QUIET: assert property (@(posedge clk) disable iff (!srst_n)
    (single_chan_i && !pio_mode_i) |-> !cap_req_o); // R9

  AST_PIO_NO_RAISE: assert property (@(posedge clk) disable iff (!srst_n)
    (pio_mode_i && !play_req_o && !cap_req_o) |=> (!play_req_o && !cap_req_o)); // R11

  AST_SINGLE_PLAY_PRIO: assert property (@(posedge clk) disable iff (!srst_n)
    (single_chan_i && !pio_mode_i && play_en_i && !eng_req[STREAM_CAP])
      |=> !eng_req[STREAM_CAP]); // R10

  AST_RESET_QUIET: assert property (@(posedge clk)
    !srst_n |-> (!play_req_o && !cap_req_o)); // R1

endmodule

// File: tb/sim_dma_req_arbiter.sv
`timescale 1ns/1ps
module sim_dma_req_arbiter;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       play_en, cap_en, single_chan, pio_mode;
  logic [1:0] sample_size;
  logic       play_need, cap_ready, play_ack, cap_ack, wr_strobe, rd_strobe;
  logic       play_req, cap_req;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  dma_req_arbiter u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .play_en_i     (play_en),
    .cap_en_i      (cap_en),
    .single_chan_i (single_chan),
    .pio_mode_i    (pio_mode),
    .sample_size_i (sample_size),
    .play_need_i   (play_need),
    .cap_ready_i   (cap_ready),
    .play_ack_i    (play_ack),
    .cap_ack_i     (cap_ack),
    .wr_strobe_i   (wr_strobe),
    .rd_strobe_i   (rd_strobe),
    .play_req_o    (play_req),
    .cap_req_o     (cap_req)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    play_en = 0; cap_en = 0; single_chan = 0; pio_mode = 0; sample_size = 0;
    play_need = 0; cap_ready = 0; play_ack = 0; cap_ack = 0;
    wr_strobe = 0; rd_strobe = 0;
  endtask

  task automatic quiet_strobes();
    play_ack = 0; cap_ack = 0; wr_strobe = 0; rd_strobe = 0;
  endtask

  // One full sample on stream s (0 = playback, 1 = capture).
  task automatic run_sample(input int s, input bit sgl, input int sz);
    int  nbytes;
    bit  on_play;
    logic tgt, oth;
    nbytes  = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    on_play = (s == 0) || sgl;
    @(negedge clk);
    idle_inputs();
    single_chan = sgl; sample_size = 2'(sz);
    if (s == 0) begin play_en = 1; play_need = 1; end
    else        begin cap_en  = 1; cap_ready = 1; end
    @(negedge clk);
    tgt = on_play ? play_req : cap_req;
    oth = on_play ? cap_req : play_req;
    check(sgl ? "R8 request on routed pin" : "R2 request raised", tgt, 1'b1);
    check(sgl ? "R9 capture pin quiet" : "R7 other pin quiet", oth, 1'b0);
    play_need = 0; cap_ready = 0;
    // stray: own strobe without acknowledge; stray capture ack in single mode
    if (s == 0) wr_strobe = 1; else rd_strobe = 1;
    if (sgl) cap_ack = 1;
    @(negedge clk);
    quiet_strobes();
    // stray: wrong-direction strobe with the routed acknowledge
    if (s == 0) rd_strobe = 1; else wr_strobe = 1;
    if (on_play) play_ack = 1; else cap_ack = 1;
    @(negedge clk);
    quiet_strobes();
    check("R4 unqualified strobes not counted", on_play ? play_req : cap_req, 1'b1);
    for (int i = 0; i < nbytes; i++) begin
      if (s == 0) wr_strobe = 1; else rd_strobe = 1;
      if (on_play) play_ack = 1; else cap_ack = 1;
      #1;
      check("R3 request vs byte index", on_play ? play_req : cap_req,
            (i != nbytes - 1) ? 1'b1 : 1'b0);
      @(negedge clk);
    end
    quiet_strobes();
    check("R3 request low after sample", on_play ? play_req : cap_req, 1'b0);
    play_en = 0; cap_en = 0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 play request in reset", play_req, 1'b0);
    check("R1 capture request in reset", cap_req, 1'b0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R1 play request after reset", play_req, 1'b0);
    check("R1 capture request after reset", cap_req, 1'b0);

    // Sweep: mode x stream x size code
    for (int sg = 0; sg < 2; sg++)
      for (int s = 0; s < 2; s++)
        for (int sz = 0; sz < 4; sz++)
          run_sample(s, sg[0], sz);

    // R6: enable low, flags high
    @(negedge clk);
    idle_inputs(); play_need = 1; cap_ready = 1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R6 play disabled", play_req, 1'b0);
      check("R6 capture disabled", cap_req, 1'b0);
    end

    // R5: disable races a pending request (playback, 2-byte samples)
    idle_inputs(); sample_size = 2'd1; play_en = 1; play_need = 1;
    @(negedge clk);
    check("R5 request up", play_req, 1'b1);
    play_en = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R5 request held after disable", play_req, 1'b1);
    end
    for (int i = 0; i < 2; i++) begin
      wr_strobe = 1; play_ack = 1; #1;
      check("R5 final sample bytes", play_req, (i == 0) ? 1'b1 : 1'b0);
      @(negedge clk);
    end
    quiet_strobes();
    for (int k = 0; k < 3; k++) begin
      check("R5 no new request after final sample", play_req, 1'b0);
      @(negedge clk);
    end

    // R7: dual mode independence
    idle_inputs(); play_en = 1; cap_en = 1; play_need = 1; cap_ready = 1;
    @(negedge clk);
    check("R7 play up", play_req, 1'b1);
    check("R7 capture up", cap_req, 1'b1);
    play_need = 0; cap_ready = 0;
    rd_strobe = 1; cap_ack = 1; #1;
    check("R7 capture done", cap_req, 1'b0);
    check("R7 play untouched", play_req, 1'b1);
    @(negedge clk);
    quiet_strobes();
    check("R7 play still up", play_req, 1'b1);
    wr_strobe = 1; play_ack = 1;
    @(negedge clk);
    quiet_strobes();
    check("R7 play done", play_req, 1'b0);

    // R10: single mode, both enabled -> playback only
    idle_inputs(); single_chan = 1; play_en = 1; cap_en = 1;
    play_need = 1; cap_ready = 1;
    @(negedge clk);
    check("R10 playback served", play_req, 1'b1);
    check("R10 capture pin quiet", cap_req, 1'b0);
    wr_strobe = 1; play_ack = 1; #1;
    check("R10 playback sample done", play_req, 1'b0);
    @(negedge clk);
    quiet_strobes(); play_need = 0;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      check("R10 capture blocked", play_req, 1'b0);
    end
    play_en = 0;
    @(negedge clk);
    check("R10 capture after playback off", play_req, 1'b1);
    cap_ready = 0; rd_strobe = 1; play_ack = 1;
    @(negedge clk);
    quiet_strobes(); cap_en = 0;
    check("R10 capture sample done", play_req, 1'b0);

    // R11: programmed I/O, both routing settings
    for (int sg = 0; sg < 2; sg++) begin
      idle_inputs(); pio_mode = 1; single_chan = sg[0];
      play_en = 1; cap_en = 1; play_need = 1; cap_ready = 1;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check("R11 play quiet in pio", play_req, 1'b0);
        check("R11 capture quiet in pio", cap_req, 1'b0);
      end
    end
    idle_inputs();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule